// File: doc/BRIEF.md
# Three-Byte Column Diffusion Unit

This unit applies the diffusion layer of a 96-bit block transform. The state holds twelve bytes, seen as four columns of three bytes each. Every column is multiplied over GF(2^8) by a symmetric 3x3 matrix that has 3 on the diagonal and 2 everywhere else. The symmetry lets each column be computed from its byte parity. The parity is doubled once, and that one value is XORed into each byte of the column. No byte needs a multiply of its own.

A caller presents the state and pulses a start strobe. The unit then works through the columns one per clock. A single doubling stage is shared by all columns. Doubling is a fixed shift plus a masked XOR, so the work takes the same cycles and the same logic path whatever the data. When the last column has been written, a one-cycle done pulse marks the result as valid on the output.

Top module: `col_mix3`

## Requirements
- R1: Byte k of a state vector lies in bits [8k+7:8k]. Column c is formed by bytes 3c, 3c+1 and 3c+2, and in_i of column c is byte 3c+i.
- R2: Each result byte is out_i = 3·in_i ⊕ 2·in_j ⊕ 2·in_k over GF(2^8), where j and k are the other two bytes of the same column.
- R3: Doubling shifts the byte left by one and XORs 0x1B when the bit shifted out was 1. A column (0x80,0,0) gives (0x9B,0x1B,0x1B), and a column (0x40,0,0) gives (0xC0,0x80,0x80).
- R4: A start sampled at clock edge n while the unit is idle makes done_o high for exactly one cycle, after edge n+4. At that point state_o holds the full result.
- R5: The columns are updated in the order 0,1,2,3, one per edge from edge n+1. After edge n+2, columns 0 and 1 hold results and columns 2 and 3 still hold input bytes.
- R6: A start that arrives while a transform is in progress is ignored. The running result and its done timing are unchanged.
- R7: After done_o, state_o keeps the result until the next accepted start, whatever state_i does.
- R8: During and after reset, done_o is 0, state_o is all zeros and the unit is idle.
- R9: A column whose three bytes XOR to zero comes out unchanged, and an all-zero state gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| state_i | input | 96 | State to transform, sampled with an accepted start |
| state_o | output | 96 | Working state; holds the full result from done onward |
| done_o | output | 1 | One-cycle pulse when the result is complete |

## Verification
The hardest case to reach from the ports is a second start arriving mid-transform. It must leave the column counter and the partly updated state untouched, and that is only visible if the bench strikes while the unit is busy. The bench drives that strobe one cycle after an accepted start, using a different state. It then expects the first state's result with unchanged done timing. The bench also samples state_o halfway through a run, where finished and untouched columns sit side by side, to pin down the column order. Bytes with the top bit set bring out the reduction path.

// File: rtl/col_mix3_pkg.sv
package col_mix3_pkg;
    parameter int BYTE_W  = 8;
    parameter int ROWS    = 3;
    parameter int COLS    = 4;
    parameter logic [BYTE_W-1:0] RED_POLY = 8'h1B;

    localparam int COL_W   = ROWS * BYTE_W;
    localparam int STATE_W = COLS * COL_W;
    localparam int CNT_W   = (COLS > 1) ? $clog2(COLS) : 1;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [COL_W-1:0]   col_t;
    typedef logic [STATE_W-1:0] state_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    localparam cnt_t LAST_COL = cnt_t'(COLS - 1);
endpackage

// File: rtl/gf_dbl.sv
module gf_dbl
    import col_mix3_pkg::*;
(
    input  byte_t a_i,
    output byte_t y_i
);
    byte_t shifted;
    byte_t mask;

    always_comb begin
        shifted = {a_i[BYTE_W-2:0], 1'b0};
        mask    = {BYTE_W{a_i[BYTE_W-1]}};
        y_i     = shifted ^ (RED_POLY & mask);
    end
endmodule

// File: rtl/col_mixer.sv
module col_mixer
    import col_mix3_pkg::*;
(
    input  col_t col_i,
    output col_t col_o
);
    byte_t parity;
    byte_t par_dbl;

    always_comb begin
        parity = '0;
        for (int r = 0; r < ROWS; r++) begin
            parity = parity ^ col_i[r*BYTE_W +: BYTE_W];
        end
    end

    gf_dbl u_dbl (
        .a_i (parity),
        .y_i (par_dbl)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign col_o[g*BYTE_W +: BYTE_W] = par_dbl ^ col_i[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/col_seq.sv
module col_seq
    import col_mix3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output cnt_t col_o,
    output logic last_o,
    output logic done_o
);
    typedef struct packed {
        logic busy;
        cnt_t col;
        logic done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        accept_o   = start_i && !seq_q.busy;
        last_o     = seq_q.busy && (seq_q.col == LAST_COL);
        if (accept_o) begin
            seq_d.busy = 1'b1;
            seq_d.col  = '0;
        end else if (seq_q.busy) begin
            if (seq_q.col == LAST_COL) begin
                seq_d.busy = 1'b0;
                seq_d.col  = '0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.col = seq_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = seq_q.busy;
    assign col_o  = seq_q.col;
    assign done_o = seq_q.done;
endmodule

// File: rtl/col_mix3.sv
module col_mix3
    import col_mix3_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [95:0] state_i,
    output logic [95:0] state_o,
    output logic        done_o
);
    typedef struct packed {
        state_t work;
    } dp_t;

    dp_t  dp_d, dp_q;
    logic accept;
    logic busy;
    cnt_t col_idx;
    logic last_col;
    col_t col_cur;
    col_t col_mixed;

    col_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .col_o    (col_idx),
        .last_o   (last_col),
        .done_o   (done_o)
    );

    assign col_cur = dp_q.work[col_idx*COL_W +: COL_W];

    col_mixer u_mix (
        .col_i (col_cur),
        .col_o (col_mixed)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.work = state_i;
        end else if (busy) begin
            dp_d.work[col_idx*COL_W +: COL_W] = col_mixed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign state_o = dp_q.work;
endmodule

// File: rtl/col_mix3_chk.sv
module col_mix3_chk
    import col_mix3_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [95:0] state_o,
    input logic        done_o,
    input logic        busy,
    input cnt_t        col_idx,
    input logic        last_col
);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && last_col |=> done_o && !busy);

    // R5
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last_col |=> busy && (col_idx == $past(col_idx) + 1'b1));

    // R6
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start_i |=> busy && (col_idx == '0));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start_i |=> $stable(state_o));

    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);
endmodule

bind col_mix3 col_mix3_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .state_o  (state_o),
    .done_o   (done_o),
    .busy     (busy),
    .col_idx  (col_idx),
    .last_col (last_col)
);

// File: tb/col_mix3_bench.sv
module col_mix3_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [95:0] state_i = '0;
    logic [95:0] state_o;
    logic        done_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    col_mix3 u_col_mix3 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .state_i (state_i),
        .state_o (state_o),
        .done_o  (done_o)
    );

    localparam int NVEC = 6;
    localparam logic [95:0] VECS [NVEC] = '{
        96'h0123456789ABCDEF_FEDCBA98,
        96'h000000000000000000000000,
        96'h808080_808080_808080_808080,
        96'hFFFFFF_FFFFFF_FFFFFF_FFFFFF,
        96'h263412_263412_263412_263412,
        96'hD4BF5D_30E0B4_52AEB841_11F1
    };

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return acc;
    endfunction

    // R1, R2: direct matrix product per column, bytes 3c..3c+2
    function automatic logic [95:0] model(input logic [95:0] v, input int ncols);
        logic [95:0] r = v;
        for (int c = 0; c < ncols; c++) begin
            logic [7:0] b [3];
            for (int i = 0; i < 3; i++) b[i] = v[(3*c+i)*8 +: 8];
            for (int i = 0; i < 3; i++) begin
                logic [7:0] o = 8'h00;
                for (int j = 0; j < 3; j++)
                    o = o ^ gmul(b[j], (i == j) ? 8'h03 : 8'h02);
                r[(3*c+i)*8 +: 8] = o;
            end
        end
        return r;
    endfunction

    task automatic check_v(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_b(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // start sampled at edge n; checks at negedges after n+2, n+3, n+4, n+5
    task automatic run_vec(input logic [95:0] v, input logic [95:0] exp);
        @(negedge clk); start_i = 1'b1; state_i = v;
        @(negedge clk); start_i = 1'b0; state_i = ~v;
        @(negedge clk);
        @(negedge clk);
        check_v("R5 partial after two columns", state_o, model(v, 2));
        @(negedge clk);
        check_b("R4 done not early", done_o, 1'b0);
        @(negedge clk);
        check_b("R4 done pulse", done_o, 1'b1);
        check_v("R2 result", state_o, exp);
        @(negedge clk);
        check_b("R4 done one cycle", done_o, 1'b0);
        check_v("R7 result held", state_o, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        check_b("R8 done in reset", done_o, 1'b0);
        check_v("R8 state in reset", state_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_b("R8 done after reset", done_o, 1'b0);
        check_v("R8 state after reset", state_o, '0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k], model(VECS[k], 4));
        end

        // R3 reduction corner with explicit constants
        run_vec(96'h000000_000000_000000_1B1B9B ^ 96'h1B1B1B, 96'h1B1B9B);
        run_vec({24'h000040, 72'h0}, {24'h8080C0, 72'h0});

        // R9 zero-parity columns unchanged, zero state gives zero
        run_vec(96'h263412_263412_263412_263412, 96'h263412_263412_263412_263412);
        run_vec('0, '0);

        // R6 start while busy is ignored
        @(negedge clk); start_i = 1'b1; state_i = VECS[0];
        @(negedge clk); state_i = VECS[3];
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_b("R6 done not early", done_o, 1'b0);
        @(negedge clk);
        check_b("R6 done timing kept", done_o, 1'b1);
        check_v("R6 first result kept", state_o, model(VECS[0], 4));

        // R7 idle hold while state_i moves
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); state_i = {3{32'hA5A5_0000}} ^ 96'(i);
        end
        @(negedge clk);
        check_v("R7 idle hold", state_o, model(VECS[0], 4));
        check_b("R7 no spurious done", done_o, 1'b0);

        summary();
        $finish;
    end
endmodule